// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the pending state for two interrupt classes across up to four processors: cross-processor interrupts raised by software, and periodic timer interrupts raised by a tick from an external timer. Each class has a 4-bit pending vector. Each pending bit drives one level-sensitive interrupt line to its processor. The number of processors actually present comes in on a configuration input. Bits for processors at or above that count are dropped before they reach the state.

Software reaches the block through a 64-bit CSR port addressed by word index. A single packed control word can post cross-processor interrupts, retire them and acknowledge timer interrupts for any set of processors in one write. A read of that word returns the identity of the processor that performs the read. Three more words give direct access:
- a pending view of each vector, where a write clears the masked bits;
- a request word, where a write posts cross-processor interrupts by mask.

Malformed writes raise a one-cycle error pulse and change nothing.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset both pending vectors are zero, every interrupt line is low, `csrRdata` is zero and `csrErr` is low.
- R2: A write to word 0 posts a cross-processor interrupt for each processor whose bit in data bits 15:12 is set (bit 12 is processor 0). The matching `ipiIrq` line is high from the next cycle.
- R3: In a word 0 write, data bits 11:8 clear pending cross-processor interrupts by processor. When the same write both posts and clears one processor, the clear wins.
- R4: In a word 0 write, data bits 7:4 clear pending timer interrupts by processor (bit 4 is processor 0).
- R5: A word 0 write in which data bit 28 is set and bits 15:4 are zero is accepted with no effect and no error. A word 0 write with bits 15:4 and bit 28 all zero changes nothing and pulses `csrErr` in the next cycle.
- R6: A read of word 0 returns `csrCpuId` in bits 1:0 and zero in all other bits. Read data appears one cycle after the access and holds until the next read.
- R7: Posting to a processor that is already pending, or clearing one that is not pending, leaves every pending bit unchanged.
- R8: A `timerTick` pulse sets the timer pending bit of every active processor. If a timer clear hits the same bit in the same cycle, the tick wins.
- R9: A read of word 1 returns the cross-processor pending vector in bits 3:0, and a read of word 2 returns the timer pending vector there. A write to either word clears the bits set in data bits 3:0.
- R10: A write to word 3 posts cross-processor interrupts for the processors set in data bits 3:0. A read of word 3 returns zero.
- R11: A write to word 1, 2 or 3 whose data bits 3:0 are all zero pulses `csrErr` and changes nothing.
- R12: Processor bits at or above `numCpus` are ignored by posts, clears and ticks, and raise no error. Values of `numCpus` above 4 act as 4.
- R13: Any access to a word index above 3 pulses `csrErr`, changes nothing, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| numCpus | input | 3 | Count of active processors (0 to 4) |
| timerTick | input | 1 | One-cycle tick that posts timer interrupts |
| csrValid | input | 1 | CSR access strobe |
| csrWrite | input | 1 | 1 = write, 0 = read |
| csrAddr | input | 4 | Word index of the access |
| csrWdata | input | 64 | Write data |
| csrCpuId | input | 2 | Identity of the processor making the access |
| csrRdata | output | 64 | Read data, registered |
| csrErr | output | 1 | One-cycle pulse after a malformed access |
| ipiIrq | output | 4 | Cross-processor interrupt line per processor |
| timerIrq | output | 4 | Timer interrupt line per processor |

## Verification
Every result is registered exactly once. Interrupt lines, read data and the error pulse therefore all reflect an access or tick on the first rising edge after it is presented. The bench drives each access on a falling edge and releases it on the next falling edge, and it checks all outputs at that same point. This is one full cycle after the stimulus and half a cycle clear of the edge that produced the result. An error pulse that lingers, or a state change that arrives a cycle late, shows up at that sample as a mismatch. Idempotence and masking are judged by comparing the whole pending vectors against values the bench tracks.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CPU_MAX = 4;
  localparam int CNT_W   = $clog2(CPU_MAX + 1);
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 4;

  // Word indices of the CSR map
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_IPI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_TMR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_REQ  = ADDR_W'(3);

  // Field positions inside the packed control word
  localparam int POST_LSB   = 12;
  localparam int IPICLR_LSB = 8;
  localparam int TMRCLR_LSB = 4;
  localparam int NXM_BIT    = 28;

  typedef enum logic [1:0] {RD_ZERO, RD_ID, RD_IPI, RD_TMR} rd_sel_e;

  typedef struct packed {
    logic [CPU_MAX-1:0] ipiSet;
    logic [CPU_MAX-1:0] ipiClr;
    logic [CPU_MAX-1:0] tmrSet;
    logic [CPU_MAX-1:0] tmrClr;
    logic               rdEn;
    rd_sel_e            rdSel;
    logic               err;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  numCpus,
  input  logic              timerTick,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] csrWdata,
  output strobe_t           strb
);
  logic [CPU_MAX-1:0] activeMask;
  logic [CPU_MAX-1:0] postF, ipiClrF, tmrClrF, lowMask;
  logic               nxmF;

  for (genvar g = 0; g < CPU_MAX; g++) begin : g_active
    assign activeMask[g] = (numCpus > CNT_W'(g));
  end

  assign postF   = csrWdata[POST_LSB   +: CPU_MAX];
  assign ipiClrF = csrWdata[IPICLR_LSB +: CPU_MAX];
  assign tmrClrF = csrWdata[TMRCLR_LSB +: CPU_MAX];
  assign nxmF    = csrWdata[NXM_BIT];
  assign lowMask = csrWdata[CPU_MAX-1:0];

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    strb.tmrSet = timerTick ? activeMask : '0;
    if (csrValid) begin
      strb.rdEn = !csrWrite;
      unique case (csrAddr)
        ADR_CTRL: begin
          if (!csrWrite) strb.rdSel = RD_ID;
          else if (((postF | ipiClrF | tmrClrF) == '0) && !nxmF) strb.err = 1'b1;
          else begin
            strb.ipiSet = postF   & activeMask;
            strb.ipiClr = ipiClrF & activeMask;
            strb.tmrClr = tmrClrF & activeMask;
          end
        end
        ADR_IPI: begin
          if (!csrWrite) strb.rdSel = RD_IPI;
          else if (lowMask == '0) strb.err = 1'b1;
          else strb.ipiClr = lowMask & activeMask;
        end
        ADR_TMR: begin
          if (!csrWrite) strb.rdSel = RD_TMR;
          else if (lowMask == '0) strb.err = 1'b1;
          else strb.tmrClr = lowMask & activeMask;
        end
        ADR_REQ: begin
          if (csrWrite) begin
            if (lowMask == '0) strb.err = 1'b1;
            else strb.ipiSet = lowMask & activeMask;
          end
        end
        default: strb.err = 1'b1;
      endcase
    end
  end

  // An erroneous access carries no state-changing CSR strobe
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |-> ((strb.ipiSet | strb.ipiClr | strb.tmrClr) == '0));

  // No strobe reaches a processor outside the active count
  p_mask_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.ipiSet | strb.ipiClr | strb.tmrSet | strb.tmrClr) & ~activeMask) == '0);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [1:0]         cpuId,
  output logic [CPU_MAX-1:0] ipiPend,
  output logic [CPU_MAX-1:0] tmrPend,
  output logic [DATA_W-1:0]  rdData,
  output logic               errPulse
);
  logic [CPU_MAX-1:0] ipiNext, tmrNext;
  logic [DATA_W-1:0]  rdNext;

  // Clear beats post for cross-processor; tick beats clear for timer
  assign ipiNext = (ipiPend | strb.ipiSet) & ~strb.ipiClr;
  assign tmrNext = (tmrPend & ~strb.tmrClr) | strb.tmrSet;

  always_comb begin
    rdNext = '0;
    unique case (strb.rdSel)
      RD_ID:   rdNext[1:0]         = cpuId;
      RD_IPI:  rdNext[CPU_MAX-1:0] = ipiPend;
      RD_TMR:  rdNext[CPU_MAX-1:0] = tmrPend;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipiPend  <= '0;
      tmrPend  <= '0;
      rdData   <= '0;
      errPulse <= 1'b0;
    end else begin
      ipiPend  <= ipiNext;
      tmrPend  <= tmrNext;
      errPulse <= strb.err;
      if (strb.rdEn) rdData <= rdNext;
    end
  end

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ipiClr != '0) |=> ((ipiPend & $past(strb.ipiClr)) == '0));

  p_tick_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tmrSet != '0) |=> ((tmrPend & $past(strb.tmrSet)) == $past(strb.tmrSet)));

  p_ipi_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.ipiSet | strb.ipiClr) == '0) |=> $stable(ipiPend));

  p_tmr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.tmrSet | strb.tmrClr) == '0) |=> $stable(tmrPend));
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  numCpus,
  input  logic              timerTick,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] csrWdata,
  input  logic [1:0]        csrCpuId,
  output logic [DATA_W-1:0] csrRdata,
  output logic              csrErr,
  output logic [CPU_MAX-1:0] ipiIrq,
  output logic [CPU_MAX-1:0] timerIrq
);
  strobe_t strb;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .numCpus(numCpus), .timerTick(timerTick),
    .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .strb(strb)
  );

  intc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuId(csrCpuId),
    .ipiPend(ipiIrq), .tmrPend(timerIrq), .rdData(csrRdata), .errPulse(csrErr)
  );
endmodule

// File: tb/sim_ipi_timer_intc.sv
module sim_ipi_timer_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  numCpus = 3'd4;
  logic        timerTick = 1'b0;
  logic        csrValid = 1'b0;
  logic        csrWrite = 1'b0;
  logic [3:0]  csrAddr = '0;
  logic [63:0] csrWdata = '0;
  logic [1:0]  csrCpuId = '0;
  logic [63:0] csrRdata;
  logic        csrErr;
  logic [3:0]  ipiIrq, timerIrq;

  int tests = 0;
  int fails = 0;
  logic [3:0] ipiExp = '0;
  logic [3:0] tmrExp = '0;

  always #10 clk = ~clk;

  ipi_timer_intc u0 (
    .clk(clk), .rstN(rstN), .numCpus(numCpus), .timerTick(timerTick),
    .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrCpuId(csrCpuId), .csrRdata(csrRdata),
    .csrErr(csrErr), .ipiIrq(ipiIrq), .timerIrq(timerIrq)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Present one access (and optional tick) for a cycle; outputs are then due
  task automatic access(input logic wr, input logic [3:0] adr, input logic [63:0] d,
                        input logic [1:0] id, input logic tick);
    @(negedge clk);
    csrValid = 1'b1; csrWrite = wr; csrAddr = adr; csrWdata = d;
    csrCpuId = id; timerTick = tick;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0; timerTick = 1'b0;
  endtask

  task automatic chkState(input string req, input logic errExp);
    chk(req, "ipiIrq", 64'(ipiIrq), 64'(ipiExp));
    chk(req, "timerIrq", 64'(timerIrq), 64'(tmrExp));
    chk(req, "csrErr", 64'(csrErr), 64'(errExp));
  endtask

  task automatic t_reset;
    chk("R1", "ipiIrq", 64'(ipiIrq), 64'h0);
    chk("R1", "timerIrq", 64'(timerIrq), 64'h0);
    chk("R1", "csrRdata", csrRdata, 64'h0);
    chk("R1", "csrErr", 64'(csrErr), 64'h0);
  endtask

  task automatic t_post;
    access(1, 4'd0, 64'hA000, 0, 0); ipiExp = 4'hA;
    chkState("R2", 0);
  endtask

  task automatic t_redundant;
    access(1, 4'd0, 64'h3000, 0, 0); ipiExp = 4'hB;  // cpu1 already pending
    chkState("R7", 0);
    access(1, 4'd1, 64'h4, 0, 0);                    // cpu2 not pending
    chkState("R7", 0);
  endtask

  task automatic t_clear_wins;
    access(1, 4'd0, 64'h4400, 0, 0);                 // post+clear cpu2
    chkState("R3", 0);
    access(1, 4'd0, 64'h0100, 0, 0); ipiExp = 4'hA;
    chkState("R3", 0);
  endtask

  task automatic t_timer;
    access(0, 4'd5, 64'h0, 0, 1); tmrExp = 4'hF;     // tick during unmapped read
    chkState("R8", 1);
    access(1, 4'd0, 64'h0050, 0, 0); tmrExp = 4'hA;
    chkState("R4", 0);
    access(1, 4'd2, 64'h2, 0, 1); tmrExp = 4'hF;     // tick beats clear
    chkState("R8", 0);
  endtask

  task automatic t_reads;
    access(0, 4'd1, 64'h0, 0, 0);
    chk("R9", "ipi pending read", csrRdata, 64'hA);
    access(0, 4'd2, 64'h0, 0, 0);
    chk("R9", "timer pending read", csrRdata, 64'hF);
    access(0, 4'd0, 64'h0, 2, 0);
    chk("R6", "cpu id 2", csrRdata, 64'h2);
    access(0, 4'd0, 64'h0, 3, 0);
    chk("R6", "cpu id 3", csrRdata, 64'h3);
    access(1, 4'd2, 64'h3, 0, 0); tmrExp = 4'hC;
    chkState("R9", 0);
    chk("R6", "read data held", csrRdata, 64'h3);
  endtask

  task automatic t_request;
    access(1, 4'd3, 64'h5, 0, 0); ipiExp = 4'hF;
    chkState("R10", 0);
    access(0, 4'd3, 64'h0, 1, 0);
    chk("R10", "request read", csrRdata, 64'h0);
  endtask

  task automatic t_misc_err;
    access(1, 4'd0, 64'h1000_0000, 0, 0);
    chkState("R5", 0);
    access(1, 4'd0, 64'h0000_000F, 0, 0);
    chkState("R5", 1);
    @(negedge clk);
    chk("R5", "error pulse one cycle", 64'(csrErr), 64'h0);
  endtask

  task automatic t_zero_mask;
    access(1, 4'd1, 64'hF0, 0, 0);
    chkState("R11", 1);
    access(1, 4'd3, 64'h0, 0, 0);
    chkState("R11", 1);
    access(1, 4'd2, 64'h0, 0, 0);
    chkState("R11", 1);
  endtask

  task automatic t_active;
    access(1, 4'd1, 64'hF, 0, 0); ipiExp = 4'h0;
    chkState("R9", 0);
    numCpus = 3'd2;
    access(1, 4'd3, 64'hF, 0, 0); ipiExp = 4'h3;
    chkState("R12", 0);
    access(1, 4'd2, 64'hF, 0, 0);                    // timer 0xC, bits 3:2 inactive
    chkState("R12", 0);
    access(1, 4'd0, 64'h0, 0, 1); tmrExp = 4'hF;     // error write plus tick on 2 cpus
    chkState("R12", 1);
    numCpus = 3'd7;
    access(1, 4'd1, 64'h8, 0, 0);                    // acts as 4: cpu3 clear ok
    chkState("R12", 0);
  endtask

  task automatic t_unmapped;
    access(1, 4'd0, 64'hF000, 0, 0); ipiExp = 4'hF;
    access(0, 4'd9, 64'h0, 1, 0);
    chkState("R13", 1);
    chk("R13", "unmapped read data", csrRdata, 64'h0);
    access(1, 4'd12, 64'hFFFF, 0, 0);
    chkState("R13", 1);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_redundant();
    t_clear_wins();
    t_timer();
    t_reads();
    t_request();
    t_misc_err();
    t_zero_mask();
    t_active();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule